// File: doc/BRIEF.md
# Periodic 24-bit System Tick Timer

This block is a memory-mapped periodic timer for a small processor subsystem. A 24-bit counter steps down by one on every qualified tick while the timer is enabled. When it runs out, it reloads from a software-programmed value and keeps going. Each expiry sets a sticky wrap flag and, if enabled, sends a one-cycle interrupt request. The tick is either every core clock cycle or a single-cycle strobe from an external reference, chosen by a control bit.

Software reaches three word registers over a simple synchronous bus. Word 0 is control/status, word 1 is the reload value and word 2 is the current count. Writes take effect at the clock edge where the bus strobe is sampled. Read data is registered and appears one cycle after the read strobe. The counter stays at zero for one tick before it reloads, so with a reload value N one period is N+1 ticks. Enabling the timer does not load the count at once. The first tick after enabling copies the reload value in.

Top module: `systick`

## Requirements
- R1: A synchronous active-high reset clears the control bits, the reload value, the count, the wrap flag, the read data and the interrupt output.
- R2: While enabled, the count drops by one on each qualified tick. Control bit 2 selects the tick source: 1 means every core clock cycle, 0 means a cycle in which the external strobe input is high.
- R3: While control bit 0 (enable) is clear, the count holds its value whatever the tick input does.
- R4: When the count reaches zero it stays at zero until the next qualified tick, which reloads it from the reload register. With reload value N on the core clock, interrupts recur every N+1 cycles.
- R5: Writing control with bit 0 set while the timer was disabled leaves the count unchanged. The first qualified tick after that loads the reload value, and counting down continues from there.
- R6: A write to word 2 clears the count to zero whatever the data. It also clears the wrap flag.
- R7: Control bit 16 is a read-only sticky wrap flag. It is set when the count steps from 1 to 0, and a read of word 0 returns it and then clears it.
- R8: When the count steps from 1 to 0 and control bit 1 (interrupt enable) is set, the interrupt output goes high for exactly one cycle, in the cycle the count first reads as zero. With bit 1 clear it stays low.
- R9: A reload value of zero leaves the count parked at zero, with no wraps, no flag and no interrupts, until a nonzero reload value is written.
- R10: Reads of words 1 and 2 return the 24-bit value with the upper 8 bits zero. Writes to them ignore the upper 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_tick_i | input | 1 | External reference strobe, one cycle per tick |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word select: 0 control, 1 reload, 2 current |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that the external strobe and the bus strobe are clean synchronous signals sampled at the core clock edge. They also assume an enable write happens only while no current-value write is in the same cycle. The hold-at-zero and decrement properties rely on the reload register not being written in the same cycle as the step they examine. The stimulus drives every input on the falling edge, one bus access at a time. It pulses the external strobe only between bus accesses. So each tick, write and read lands on a distinct rising edge whose effect can be predicted alone.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned CTRL_SRC_BIT  = 2;
  localparam int unsigned CTRL_FLAG_BIT = 16;

  typedef logic [1:0] word_sel_t;
  localparam word_sel_t SEL_CTRL   = 2'd0;
  localparam word_sel_t SEL_RELOAD = 2'd1;
  localparam word_sel_t SEL_CUR    = 2'd2;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/systick_tick_sel.sv
module systick_tick_sel (
  input  logic src_core_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  assign tick_o = src_core_i ? 1'b1 : ext_tick_i;
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  word_sel_t         bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_wr_o,
  output logic              arm_o,
  output logic              ctrl_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign wr        = bus_en_i & bus_we_i;
  assign rd        = bus_en_i & ~bus_we_i;
  assign cur_wr_o  = wr & (bus_addr_i == SEL_CUR);
  assign ctrl_rd_o = rd & (bus_addr_i == SEL_CTRL);
  assign arm_o     = wr & (bus_addr_i == SEL_CTRL) & bus_wdata_i[CTRL_EN_BIT] & ~ctrl_o.enable;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CNT_W];

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      SEL_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = ctrl_o.enable;
        rd_mux[CTRL_IE_BIT]   = ctrl_o.irq_en;
        rd_mux[CTRL_SRC_BIT]  = ctrl_o.src_core;
        rd_mux[CTRL_FLAG_BIT] = flag_i;
      end
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_o};
      SEL_CUR:    rd_mux = {{PAD_W{1'b0}}, count_i};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o   <= '0;
      reload_o <= '0;
      rdata_o  <= '0;
    end else begin
      if (wr && bus_addr_i == SEL_CTRL) begin
        ctrl_o.enable   <= bus_wdata_i[CTRL_EN_BIT];
        ctrl_o.irq_en   <= bus_wdata_i[CTRL_IE_BIT];
        ctrl_o.src_core <= bus_wdata_i[CTRL_SRC_BIT];
      end
      if (wr && bus_addr_i == SEL_RELOAD) reload_o <= bus_wdata_i[CNT_W-1:0];
      if (rd) rdata_o <= rd_mux;
    end
  end

  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr_i == SEL_RELOAD) |=> reload_o == $past(bus_wdata_i[CNT_W-1:0])); // R10
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr_i != SEL_CTRL) |=> rdata_o[DATA_W-1:CNT_W] == '0); // R10
endmodule

// File: rtl/systick_core.sv
module systick_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             irq_en_i,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             cur_wr_i,
  input  logic             ctrl_rd_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step, load_pend, wrap_evt, at_zero;

  assign step     = enable_i & tick_i;
  assign at_zero  = (count_o == '0);
  assign wrap_evt = step & ~cur_wr_i & ~load_pend & (count_o == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o   <= '0;
      load_pend <= 1'b0;
      flag_o    <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= wrap_evt & irq_en_i;
      if (arm_i) load_pend <= 1'b1;
      if (cur_wr_i) begin
        count_o <= '0;
      end else if (step) begin
        if (load_pend || at_zero) begin
          count_o   <= reload_i;
          load_pend <= 1'b0;
        end else begin
          count_o <= count_o - ONE;
        end
      end
      if (wrap_evt) flag_o <= 1'b1;
      else if (ctrl_rd_i || cur_wr_i) flag_o <= 1'b0;
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !cur_wr_i) |=> $stable(count_o)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (step && !cur_wr_i && !load_pend && !at_zero) |=> count_o == $past(count_o) - ONE); // R2
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (step && !cur_wr_i && at_zero) |=> count_o == $past(reload_i)); // R4
  AST_CUR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cur_wr_i |=> (count_o == '0 && !flag_o)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R8
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (count_o == '0 && flag_o)); // R8
endmodule

// File: rtl/systick.sv
module systick
  import systick_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_tick_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             cur_wr, arm, ctrl_rd, flag, tick;

  systick_tick_sel u_tick (
    .src_core_i (ctrl.src_core),
    .ext_tick_i (ext_tick_i),
    .tick_o     (tick)
  );

  systick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .count_i     (count),
    .flag_i      (flag),
    .ctrl_o      (ctrl),
    .reload_o    (reload),
    .cur_wr_o    (cur_wr),
    .arm_o       (arm),
    .ctrl_rd_o   (ctrl_rd),
    .rdata_o     (bus_rdata_o)
  );

  systick_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (ctrl.enable),
    .irq_en_i  (ctrl.irq_en),
    .tick_i    (tick),
    .arm_i     (arm),
    .cur_wr_i  (cur_wr),
    .ctrl_rd_i (ctrl_rd),
    .reload_i  (reload),
    .count_o   (count),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/systick_tb_top.sv
module systick_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CUR = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  systick dut_i (
    .clk(clk), .rst(rst), .ext_tick_i(ext_tick),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_tick(output logic got_irq);
    @(negedge clk);
    ext_tick = 1;
    @(negedge clk);
    ext_tick = 0;
    got_irq = irq;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    bus_rd(A_CTRL, v); check("R1 ctrl reset", v, 32'd0);
    bus_rd(A_RLD, v);  check("R1 reload reset", v, 32'd0);
    bus_rd(A_CUR, v);  check("R1 count reset", v, 32'd0);
  endtask

  task automatic t_upper_bits();
    logic [31:0] v;
    bus_wr(A_RLD, 32'hFF12_3456);
    bus_rd(A_RLD, v); check("R10 reload upper bits", v, 32'h0012_3456);
  endtask

  task automatic t_ext_sequence();
    logic [31:0] v; logic q;
    bus_wr(A_RLD, 32'd3);
    bus_wr(A_CUR, 32'd0);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_CUR, v); check("R5 no load at enable", v, 32'd0);
    pulse_tick(q);    bus_rd(A_CUR, v); check("R5 first tick loads", v, 32'd3);
    pulse_tick(q);    bus_rd(A_CUR, v); check("R2 ext decrement", v, 32'd2);
    pulse_tick(q);    check("R8 no irq before wrap", {31'b0, q}, 32'd0);
    pulse_tick(q);    check("R8 irq on wrap", {31'b0, q}, 32'd1);
    bus_rd(A_CUR, v); check("R4 count at zero", v, 32'd0);
    bus_rd(A_CTRL, v); check("R7 flag set", v, 32'h0001_0003);
    bus_rd(A_CTRL, v); check("R7 flag cleared by read", v, 32'h0000_0003);
    pulse_tick(q);    bus_rd(A_CUR, v); check("R4 reload after zero tick", v, 32'd3);
  endtask

  task automatic t_hold_and_rearm();
    logic [31:0] v; logic q;
    bus_wr(A_CTRL, 32'h2);
    pulse_tick(q); bus_rd(A_CUR, v); check("R3 hold while disabled", v, 32'd3);
    bus_wr(A_RLD, 32'd7);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_CUR, v); check("R5 re-enable no immediate load", v, 32'd3);
    pulse_tick(q); bus_rd(A_CUR, v); check("R5 tick after enable loads reload", v, 32'd7);
  endtask

  task automatic t_clear();
    logic [31:0] v; logic q;
    bus_wr(A_CUR, 32'h00AB_CDEF);
    bus_rd(A_CUR, v); check("R6 write clears count", v, 32'd0);
    bus_wr(A_RLD, 32'd1);
    pulse_tick(q);
    pulse_tick(q); check("R8 irq on 1-to-0", {31'b0, q}, 32'd1);
    bus_wr(A_CUR, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); check("R6 write clears flag", v & 32'h0001_0000, 32'd0);
    bus_rd(A_CUR, v); check("R10 write upper bits ignored", v, 32'd0);
  endtask

  task automatic t_irq_disabled();
    logic [31:0] v; logic q;
    bus_wr(A_CTRL, 32'h1);
    pulse_tick(q);
    pulse_tick(q); check("R8 no irq when disabled", {31'b0, q}, 32'd0);
    bus_rd(A_CTRL, v); check("R7 flag set without irq", v, 32'h0001_0001);
  endtask

  task automatic t_reload_zero();
    logic [31:0] v; logic q; int irqs = 0;
    bus_wr(A_RLD, 32'd0);
    for (int i = 0; i < 4; i++) begin
      pulse_tick(q);
      if (q) irqs++;
    end
    bus_rd(A_CUR, v); check("R9 parked at zero", v, 32'd0);
    bus_rd(A_CTRL, v); check("R9 no flag while parked", v & 32'h0001_0000, 32'd0);
    check("R9 no irq while parked", irqs, 0);
    bus_wr(A_RLD, 32'd2);
    pulse_tick(q); bus_rd(A_CUR, v); check("R9 resumes with nonzero reload", v, 32'd2);
  endtask

  task automatic t_core_periodic();
    int first = 0, second = 0;
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_RLD, 32'd5);
    bus_wr(A_CUR, 32'd0);
    bus_wr(A_CTRL, 32'h7);
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (irq) begin
        if (first == 0) first = n;
        else if (second == 0) second = n;
      end
    end
    check("R2 core clock first irq", first, 6);
    check("R4 period reload+1", second, 12);
    bus_wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_upper_bits();
    t_ext_sequence();
    t_hold_and_rearm();
    t_clear();
    t_irq_disabled();
    t_reload_zero();
    t_core_periodic();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule